// File: doc/BRIEF.md
# Core Reset and FIFO Flush Controller

This block is the reset-and-flush control register of a USB controller core. Software writes a one to a command bit to start a whole-core soft reset, a reset of the host-bus-side pipeline only, a frame-number counter reset, an IN-token queue flush, a receive FIFO flush or a transmit FIFO flush. The block drives the matching strobe toward the FIFOs and state machines, waits for the handshake or the fixed flush time, then clears the bit by itself. Software polls the same register until the bit drops.

A five-bit selector picks which transmit FIFO a TX flush empties: one FIFO or all of them. The selector is captured at the write that starts the flush and cannot be changed until the flush ends. A whole-core reset also flushes every FIFO and clears the interrupt mask register, while the interrupt status and configuration registers, both held here, keep their contents. Two read-only status bits report a DMA request input and a bus-master-idle condition.

Top module: `core_rst_ctl`

## Requirements
- R1: After reset, rd_data bits 5:0 and the selector field (bits 10:6) read 0, int_mask, cfg and int_sts read 0, and bit 31 reads 1 when mst_busy is low.
- R2: Writing 1 to bit 0 sets bit 0 and core_rst on the next edge; they stay high until sm_idle is sampled high at an edge while set, and are low after that edge.
- R3: While bit 0 is set, tx_flush is all ones and rx_flush is high.
- R4: While bit 0 is set, int_mask is cleared; cfg and int_sts are not changed by the core reset.
- R5: Writing 1 to bit 4 sets bit 4 and rx_flush for exactly FLUSH_CYC (8) cycles, then both clear.
- R6: Writing 1 to bit 5 sets bit 5 for exactly FLUSH_CYC cycles with the selector taken from wr_data[10:6] of that write; tx_flush then has bit n high for selector n (0 to 15), all bits high for selector 16, and no bit high for selectors 17 to 31.
- R7: While bit 5 is set, writes do not change the selector field or tx_flush; when bit 5 is clear a write loads the selector from wr_data[10:6].
- R8: Writing 1 to bit 1 sets bit 1 and hbus_rst, which stay high until hb_done is sampled high at an edge while set.
- R9: Writing 1 to bit 2 or bit 3 raises frm_rst or tknq_flush (and the bit) for exactly one cycle.
- R10: Bit 30 reads dma_req; bit 31 reads 1 only when bits 5:0 are all 0 and mst_busy is low.
- R11: Writing 0 to a command bit never cancels an operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 11 | Command bits 5:0 and selector 10:6 |
| rd_data | output | 32 | Command register read value |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 32 | Interrupt mask write value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| int_set | input | 32 | Interrupt status set events |
| int_clr | input | 32 | Interrupt status clear requests |
| sm_idle | input | 1 | All core state machines idle |
| hb_done | input | 1 | Host-bus pipeline reset finished |
| mst_busy | input | 1 | Bus master busy |
| dma_req | input | 1 | DMA request in progress |
| core_rst | output | 1 | Whole-core reset strobe |
| hbus_rst | output | 1 | Host-bus pipeline reset strobe |
| frm_rst | output | 1 | Frame counter reset pulse |
| tknq_flush | output | 1 | IN-token queue flush pulse |
| rx_flush | output | 1 | Receive FIFO flush strobe |
| tx_flush | output | NUM_TXF | Per-FIFO transmit flush strobes |
| int_mask | output | 32 | Interrupt mask register |
| cfg | output | 32 | Configuration register |
| int_sts | output | 32 | Interrupt status register |

## Verification
Every command bit and strobe is registered once, so each result appears after the edge that takes the write; the bench drives on falling edges and samples on the falling edge that follows, one cycle after the write. Flush lengths are measured by counting falling edges while the bit is high, which must give 8 for a fresh flush and 6 when sampling starts two cycles late. Handshake-terminated bits are checked to hold for several cycles with the handshake low and to drop on the first falling edge after the handshake was high across an edge.

// File: rtl/core_rst_ctl.sv
module core_rst_ctl #(
  parameter int NUM_TXF   = 16,
  parameter int FLUSH_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [10:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic               mask_we,
  input  logic [31:0]        mask_wdata,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  input  logic [31:0]        int_set,
  input  logic [31:0]        int_clr,
  input  logic               sm_idle,
  input  logic               hb_done,
  input  logic               mst_busy,
  input  logic               dma_req,
  output logic               core_rst,
  output logic               hbus_rst,
  output logic               frm_rst,
  output logic               tknq_flush,
  output logic               rx_flush,
  output logic [NUM_TXF-1:0] tx_flush,
  output logic [31:0]        int_mask,
  output logic [31:0]        cfg,
  output logic [31:0]        int_sts
);
  localparam int CW = $clog2(FLUSH_CYC + 1);
  localparam logic [4:0] SEL_ALL = 5'd16;

  logic          core_q, hb_q, frm_q, tkn_q, rx_q, tx_q;
  logic [4:0]    sel_q;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= 1'b0; hb_q <= 1'b0; frm_q <= 1'b0; tkn_q <= 1'b0;
      rx_q <= 1'b0; tx_q <= 1'b0; sel_q <= '0;
      rx_cnt <= '0; tx_cnt <= '0;
      int_mask <= '0; cfg <= '0; int_sts <= '0;
    end else begin
      if (wr_en && wr_data[0]) core_q <= 1'b1;
      else if (core_q && sm_idle) core_q <= 1'b0;

      if (wr_en && wr_data[1]) hb_q <= 1'b1;
      else if (hb_q && hb_done) hb_q <= 1'b0;

      frm_q <= wr_en && wr_data[2];
      tkn_q <= wr_en && wr_data[3];

      if (!rx_q) begin
        if (wr_en && wr_data[4]) begin
          rx_q   <= 1'b1;
          rx_cnt <= CW'(FLUSH_CYC - 1);
        end
      end else if (rx_cnt == '0) rx_q <= 1'b0;
      else rx_cnt <= rx_cnt - 1'b1;

      if (!tx_q) begin
        if (wr_en) sel_q <= wr_data[10:6];
        if (wr_en && wr_data[5]) begin
          tx_q   <= 1'b1;
          tx_cnt <= CW'(FLUSH_CYC - 1);
        end
      end else if (tx_cnt == '0) tx_q <= 1'b0;
      else tx_cnt <= tx_cnt - 1'b1;

      if (core_q) int_mask <= '0;
      else if (mask_we) int_mask <= mask_wdata;

      if (cfg_we) cfg <= cfg_wdata;
      int_sts <= (int_sts & ~int_clr) | int_set;
    end
  end

  for (genvar i = 0; i < NUM_TXF; i++) begin : g_txf
    assign tx_flush[i] = core_q | (tx_q & ((sel_q == 5'(i)) | (sel_q == SEL_ALL)));
  end

  assign core_rst   = core_q;
  assign hbus_rst   = hb_q;
  assign frm_rst    = frm_q;
  assign tknq_flush = tkn_q;
  assign rx_flush   = core_q | rx_q;
  assign idle       = !(core_q | hb_q | frm_q | tkn_q | rx_q | tx_q) && !mst_busy;
  assign rd_data    = {idle, dma_req, 19'b0, sel_q, tx_q, rx_q, tkn_q, frm_q, hb_q, core_q};

  logic [CW:0] rx_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_run <= '0;
    else rx_run <= rd_data[4] ? rx_run + 1'b1 : '0;

  assert_rx_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> (int'(rx_run) < FLUSH_CYC));
  assert_rx_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[4]) |-> (int'($past(rx_run)) == FLUSH_CYC - 1));
  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] && $past(rd_data[5])) |-> $stable(rd_data[10:6]));
  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |=> (int_mask == '0));
  assert_cfg_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !cfg_we) |=> $stable(cfg));
  assert_core_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && sm_idle && !(wr_en && wr_data[0])) |=> !core_rst);
  assert_flush_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (&tx_flush && rx_flush));
  assert_one_fifo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && rd_data[10:6] != SEL_ALL) |-> $onehot0(tx_flush));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |-> (rd_data[5:0] == 6'b0 && !mst_busy));
endmodule

// File: tb/test_core_rst_ctl.sv
module test_core_rst_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [10:0] wr_data = '0;
  logic [31:0] rd_data;
  logic mask_we = 1'b0, cfg_we = 1'b0;
  logic [31:0] mask_wdata = '0, cfg_wdata = '0, int_set = '0, int_clr = '0;
  logic sm_idle = 1'b1, hb_done = 1'b0, mst_busy = 1'b0, dma_req = 1'b0;
  logic core_rst, hbus_rst, frm_rst, tknq_flush, rx_flush;
  logic [NT-1:0] tx_flush;
  logic [31:0] int_mask, cfg, int_sts;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_rst_ctl #(.NUM_TXF(NT), .FLUSH_CYC(8)) i_core_rst_ctl (
    .clk, .rst_n, .wr_en, .wr_data, .rd_data, .mask_we, .mask_wdata,
    .cfg_we, .cfg_wdata, .int_set, .int_clr, .sm_idle, .hb_done, .mst_busy,
    .dma_req, .core_rst, .hbus_rst, .frm_rst, .tknq_flush, .rx_flush,
    .tx_flush, .int_mask, .cfg, .int_sts);

  // {selector, expected tx_flush}
  localparam int NV = 6;
  localparam logic [20:0] TXV [NV] = '{
    {5'd0,  16'h0001}, {5'd1,  16'h0002}, {5'd7,  16'h0080},
    {5'd15, 16'h8000}, {5'd16, 16'hFFFF}, {5'd20, 16'h0000}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run_len(int bitn, output int n);
    n = 0;
    while (rd_data[bitn] && n < 40) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 cmd", rd_data, 32'h8000_0000);
    check("R1 mask", int_mask, 0);
    check("R1 cfg", cfg, 0);
    check("R1 sts", int_sts, 0);

    // R6 table walk
    for (int v = 0; v < NV; v++) begin
      wr({TXV[v][20:16], 6'b10_0000});
      check("R6 sel", 32'(rd_data[10:6]), 32'(TXV[v][20:16]));
      check("R6 vec", 32'(tx_flush), 32'(TXV[v][15:0]));
      run_len(5, n);
      check("R6 len", n, 8);
      check("R6 end", 32'(tx_flush), 0);
    end

    // R7
    wr({5'd3, 6'b10_0000});
    wr({5'd9, 6'b00_0000});
    check("R7 sel held", 32'(rd_data[10:6]), 3);
    check("R7 vec held", 32'(tx_flush), 32'h0008);
    run_len(5, n);
    wr({5'd9, 6'b00_0000});
    check("R7 sel load", 32'(rd_data[10:6]), 9);

    // R5 and R10 idle during flush
    wr(11'h010);
    check("R5 rx", 32'(rx_flush), 1);
    check("R10 busy", 32'(rd_data[31]), 0);
    run_len(4, n);
    check("R5 len", n, 8);
    check("R5 end", 32'(rx_flush), 0);

    // R11
    wr(11'h010);
    wr(11'h000);
    check("R11 still", 32'(rx_flush), 1);
    run_len(4, n);
    check("R11 len", n, 6);

    // R9
    wr(11'h00C);
    check("R9 frm", 32'(frm_rst), 1);
    check("R9 tkn", 32'(tknq_flush), 1);
    @(negedge clk);
    check("R9 frm off", 32'(frm_rst), 0);
    check("R9 tkn off", 32'(tknq_flush), 0);

    // R8
    hb_done = 1'b0;
    wr(11'h002);
    repeat (3) begin check("R8 hold", 32'(hbus_rst), 1); @(negedge clk); end
    hb_done = 1'b1;
    @(negedge clk);
    hb_done = 1'b0;
    check("R8 end", 32'(rd_data[1]), 0);

    // R2 R3 R4
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = 32'h0000_FFFF;
    cfg_we = 1'b1; cfg_wdata = 32'h0000_1234;
    int_set = 32'h0000_000A;
    @(negedge clk);
    mask_we = 1'b0; cfg_we = 1'b0; int_set = '0;
    check("R4 mask set", int_mask, 32'h0000_FFFF);
    sm_idle = 1'b0;
    wr(11'h001);
    repeat (3) begin
      check("R2 hold", 32'(core_rst), 1);
      check("R3 tx all", 32'(tx_flush), 32'h0000_FFFF);
      check("R3 rx", 32'(rx_flush), 1);
      @(negedge clk);
    end
    check("R4 mask clr", int_mask, 0);
    sm_idle = 1'b1;
    @(negedge clk);
    check("R2 end", 32'(rd_data[0]), 0);
    check("R4 cfg", cfg, 32'h0000_1234);
    check("R4 sts", int_sts, 32'h0000_000A);

    // R10
    dma_req = 1'b1; mst_busy = 1'b1;
    @(negedge clk);
    check("R10 dma busy", rd_data[31:30], 2'b01);
    dma_req = 1'b0; mst_busy = 1'b0;
    @(negedge clk);
    check("R10 idle", rd_data[31:30], 2'b10);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule